// File: doc/BRIEF.md
# Multiplexed 8-bit Bus Master

This block turns single host register accesses into complete bus cycles on a shared 8-bit address/data bus with separate address-latch, read and write strobes. Between cycles the bus sits in its address phase: the current address is driven on the AD lines and the address latch strobe is asserted, so any attached peripheral holds a valid address at all times. The host loads the address through a write-only alias. It then reads or writes one of two data aliases. Each such access runs exactly one bus cycle, and the second alias also increments the address after the cycle, which allows back-to-back accesses to consecutive locations.

A cycle runs through four timed phases: address hold with the latch strobe released, turnaround, the read or write pulse, and data hold. The latch strobe then returns. Phase lengths are given in nanoseconds together with the sequencer clock period. Each is rounded up to whole clock cycles. An optional late-latch setting stretches the data hold. Strobe polarity is not fixed: each strobe asserts at the inverse of its programmed idle level. A strobe whose pin is configured as an input is never toggled.

Top module: `mux8_bus_master`

## Requirements
- R1: After reset and whenever no cycle is running, `ad_oe` is 1, `ad_o` carries the address register (reset value 0x00), `host_busy` is 0, the latch strobe is asserted and both data strobes are deasserted.
- R2: A host write with `host_sel`=0 loads the address register, which appears on `ad_o` on the next cycle. A host read with `host_sel`=0 starts no bus cycle, and `host_sel`=3 is ignored.
- R3: An accepted data access (`host_sel` 1 or 2) is followed by address hold for ceil(13 ns / Tclk) cycles, turnaround for ceil(6 ns / Tclk), strobe for ceil(55 ns / Tclk) and data hold for ceil(6 ns / Tclk) cycles, in that order. The latch strobe is deasserted throughout and the address is still driven during address hold.
- R4: In a read cycle (`host_we`=0), `ad_oe` is 0 from turnaround through data hold, the read strobe is asserted during the strobe phase, and `host_rdata` takes the value on `ad_i` in the last strobe cycle.
- R5: In a write cycle (`host_we`=1), `ad_o` carries the write data with `ad_oe`=1 from turnaround until the latch strobe reasserts, and the write strobe is asserted during the strobe phase.
- R6: After a cycle through `host_sel`=2, the address increments by one and wraps from 0xFF to 0x00. `host_sel`=1 leaves the address unchanged.
- R7: Strobe bit order in `idle_lvl` and `pin_dir` is [0] latch, [1] read, [2] write. Each strobe shows its `idle_lvl` bit when deasserted and the inverse of that bit when asserted.
- R8: A strobe whose `pin_dir` bit is 0 stays at its `idle_lvl` bit at all times, and its `strobe_oe` bit is 0. A strobe with `pin_dir`=1 has `strobe_oe`=1.
- R9: `host_busy` rises on the cycle after the accepting clock edge and stays 1 until the latch strobe reasserts. Requests made while busy are ignored.
- R10: With `LATE_ALE`=1 (the default), the data hold phase is lengthened by 4 ns before rounding, which gives ceil(10 ns / Tclk) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access strobe, one cycle |
| host_sel | input | 2 | Alias: 0 address, 1 data, 2 data with increment, 3 unused |
| host_we | input | 1 | 1 for a write access, 0 for a read |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Data captured by the last read cycle |
| host_busy | output | 1 | Bus cycle in progress |
| idle_lvl | input | 3 | Idle level per strobe |
| pin_dir | input | 3 | 1 = strobe pin is an output |
| ad_o | output | 8 | AD output value |
| ad_oe | output | 1 | AD output enable |
| ad_i | input | 8 | AD input value |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| strobe_oe | output | 3 | Output enable per strobe pin |

## Verification
The assertions assume that the host does not change `idle_lvl` or `pin_dir` while `host_busy` is high. Otherwise the relationship between strobe levels and cycle phase would be undefined. The bench changes these inputs only between cycles, after it has seen `host_busy` low. It holds `ad_i` steady across each read cycle, so the captured value does not depend on the sampling instant. It also issues each request as a single-cycle pulse while the block is idle, apart from one deliberate request made while busy to exercise R9.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ADDR = 3'd1,
      PH_TURN = 3'd2,
      PH_STRB = 3'd3,
      PH_HOLD = 3'd4
   } phase_e;

   localparam int STB_ALE = 0;
   localparam int STB_RD  = 1;
   localparam int STB_WR  = 2;
   localparam int NUM_STB = 3;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_DATA = 2'd1;
   localparam logic [1:0] SEL_INC  = 2'd2;

   function automatic int ns_to_cyc(input int ns, input int clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction
endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
   import mbm_pkg::*;
#(
   parameter int A_CYC = 4,
   parameter int T_CYC = 2,
   parameter int S_CYC = 14,
   parameter int H_CYC = 3
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_e phase,
   output logic   strobe_end,
   output logic   cyc_done
);
   localparam int MAXC = (A_CYC > S_CYC) ? ((A_CYC > H_CYC) ? A_CYC : H_CYC)
                                        : ((S_CYC > H_CYC) ? S_CYC : H_CYC);
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt;
   logic          cnt_zero;

   assign cnt_zero   = (cnt == '0);
   assign strobe_end = (phase == PH_STRB) && cnt_zero;
   assign cyc_done   = (phase == PH_HOLD) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_ADDR;
               cnt   <= CW'(A_CYC - 1);
            end
            PH_ADDR: if (cnt_zero) begin
               phase <= PH_TURN;
               cnt   <= CW'(T_CYC - 1);
            end else cnt <= cnt - 1'b1;
            PH_TURN: if (cnt_zero) begin
               phase <= PH_STRB;
               cnt   <= CW'(S_CYC - 1);
            end else cnt <= cnt - 1'b1;
            PH_STRB: if (cnt_zero) begin
               phase <= PH_HOLD;
               cnt   <= CW'(H_CYC - 1);
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (cnt_zero) phase <= PH_IDLE;
                     else cnt <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mbm_strobe.sv
module mbm_strobe (
   input  logic active,
   input  logic idle_bit,
   input  logic dir_out,
   output logic pin_o,
   output logic pin_oe
);
   assign pin_o  = (dir_out && active) ? ~idle_bit : idle_bit;
   assign pin_oe = dir_out;
endmodule

// File: rtl/mux8_bus_master.sv
module mux8_bus_master
   import mbm_pkg::*;
#(
   parameter int AW        = 8,
   parameter int CLK_PS    = 4000,
   parameter int T_ADDR_NS = 13,
   parameter int T_TURN_NS = 6,
   parameter int T_STRB_NS = 55,
   parameter int T_HOLD_NS = 6,
   parameter bit LATE_ALE  = 1'b1,
   parameter int T_LATE_NS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_req,
   input  logic [1:0]    host_sel,
   input  logic          host_we,
   input  logic [AW-1:0] host_wdata,
   output logic [AW-1:0] host_rdata,
   output logic          host_busy,
   input  logic [2:0]    idle_lvl,
   input  logic [2:0]    pin_dir,
   output logic [AW-1:0] ad_o,
   output logic          ad_oe,
   input  logic [AW-1:0] ad_i,
   output logic          ale_o,
   output logic          rd_o,
   output logic          wr_o,
   output logic [2:0]    strobe_oe
);
   localparam int HOLD_NS = T_HOLD_NS + (LATE_ALE ? T_LATE_NS : 0);
   localparam int A_CYC   = ns_to_cyc(T_ADDR_NS, CLK_PS);
   localparam int T_CYC   = ns_to_cyc(T_TURN_NS, CLK_PS);
   localparam int S_CYC   = ns_to_cyc(T_STRB_NS, CLK_PS);
   localparam int H_CYC   = ns_to_cyc(HOLD_NS, CLK_PS);

   if (AW < 1 || AW > 32) begin : g_bad_aw
      $error("mux8_bus_master: AW out of range");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("mux8_bus_master: CLK_PS must be positive");
   end
   if (A_CYC < 1 || T_CYC < 1 || S_CYC < 1 || H_CYC < 1) begin : g_bad_phase
      $error("mux8_bus_master: every phase needs at least one cycle");
   end

   phase_e        phase;
   logic          strobe_end, cyc_done;
   logic          accept, start, addr_wr;
   logic [AW-1:0] addr_q, wdata_q, rdata_q;
   logic          is_wr_q, inc_q;
   logic          in_addr_phase;
   logic [2:0]    stb_act, stb_pin;

   assign host_busy = (phase != PH_IDLE);
   assign accept    = host_req && !host_busy;
   assign addr_wr   = accept && host_we && (host_sel == SEL_ADDR);
   assign start     = accept && ((host_sel == SEL_DATA) || (host_sel == SEL_INC));

   mbm_seq #(
      .A_CYC(A_CYC), .T_CYC(T_CYC), .S_CYC(S_CYC), .H_CYC(H_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .phase      (phase),
      .strobe_end (strobe_end),
      .cyc_done   (cyc_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         is_wr_q <= 1'b0;
         inc_q   <= 1'b0;
      end else begin
         if (addr_wr) addr_q <= host_wdata;
         if (start) begin
            wdata_q <= host_wdata;
            is_wr_q <= host_we;
            inc_q   <= (host_sel == SEL_INC);
         end
         if (strobe_end && !is_wr_q) rdata_q <= ad_i;
         if (cyc_done && inc_q) addr_q <= addr_q + 1'b1;
      end
   end

   assign host_rdata    = rdata_q;
   assign in_addr_phase = (phase == PH_IDLE) || (phase == PH_ADDR);
   assign ad_oe         = in_addr_phase || is_wr_q;
   assign ad_o          = in_addr_phase ? addr_q : wdata_q;

   assign stb_act[STB_ALE] = (phase == PH_IDLE);
   assign stb_act[STB_RD]  = (phase == PH_STRB) && !is_wr_q;
   assign stb_act[STB_WR]  = (phase == PH_STRB) && is_wr_q;

   for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
      mbm_strobe u_stb (
         .active   (stb_act[g]),
         .idle_bit (idle_lvl[g]),
         .dir_out  (pin_dir[g]),
         .pin_o    (stb_pin[g]),
         .pin_oe   (strobe_oe[g])
      );
   end

   assign ale_o = stb_pin[STB_ALE];
   assign rd_o  = stb_pin[STB_RD];
   assign wr_o  = stb_pin[STB_WR];
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_req,
   input logic [1:0]    host_sel,
   input logic          host_we,
   input logic          host_busy,
   input logic [2:0]    idle_lvl,
   input logic [2:0]    pin_dir,
   input logic          ad_oe,
   input logic          ale_o,
   input logic          rd_o,
   input logic          wr_o
);
   // R1: idle bus keeps the latch strobe asserted
   a_r1_idle_ale: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_busy && pin_dir[0]) |-> (ale_o != idle_lvl[0]));

   // R9: latch strobe released for the whole busy period
   a_r9_busy_ale_off: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy |-> (ale_o == idle_lvl[0]));

   // R4: AD released whenever the read strobe is asserted
   a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_o != idle_lvl[1]) |-> !ad_oe);

   // R7: read and write strobes never asserted together
   a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !((rd_o != idle_lvl[1]) && (wr_o != idle_lvl[2])));

   // R8: input-direction read pin never toggles
   a_r8_rd_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_dir[1] |-> (rd_o == idle_lvl[1]));

   // R2: address alias starts no cycle
   a_r2_addr_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_busy && host_sel == 2'd0) |=> !host_busy);

   // R9: busy follows an accepted data access
   a_r9_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_busy && (host_sel == 2'd1 || host_sel == 2'd2)) |=> host_busy);

   wire unused_ok = host_we;
endmodule

bind mux8_bus_master mbm_checker #(.AW(AW)) u_mbm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_req  (host_req),
   .host_sel  (host_sel),
   .host_we   (host_we),
   .host_busy (host_busy),
   .idle_lvl  (idle_lvl),
   .pin_dir   (pin_dir),
   .ad_oe     (ad_oe),
   .ale_o     (ale_o),
   .rd_o      (rd_o),
   .wr_o      (wr_o)
);

// File: tb/tb_mux8_bus_master.sv
`timescale 1ns/1ps
module tb_mux8_bus_master;
   localparam int CA  = (13000 + 3999) / 4000;
   localparam int CT  = (6000 + 3999) / 4000;
   localparam int CS  = (55000 + 3999) / 4000;
   localparam int CH  = (10000 + 3999) / 4000;   // R10: 6 ns + 4 ns late latch
   localparam int TOT = CA + CT + CS + CH;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_req = 1'b0;
   logic [1:0] host_sel = 2'd0;
   logic       host_we = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       host_busy;
   logic [2:0] idle_lvl = 3'b111;
   logic [2:0] pin_dir = 3'b111;
   logic [7:0] ad_o;
   logic       ad_oe;
   logic [7:0] ad_i = 8'h00;
   logic       ale_o, rd_o, wr_o;
   logic [2:0] strobe_oe;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m_addr = 8'h00;
   logic [7:0] m_rdata = 8'h00;

   always #2 clk = ~clk;

   mux8_bus_master dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_sel(host_sel),
      .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_busy(host_busy), .idle_lvl(idle_lvl), .pin_dir(pin_dir),
      .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ale_o(ale_o), .rd_o(rd_o),
      .wr_o(wr_o), .strobe_oe(strobe_oe)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // phase: 0 idle, 1 addr hold, 2 turnaround, 3 strobe, 4 data hold
   function automatic int phase_at(input int t);
      if (t < CA) return 1;
      if (t < CA + CT) return 2;
      if (t < CA + CT + CS) return 3;
      return 4;
   endfunction

   task automatic expect_state(input string tag, input int ph, input logic wr, input logic [7:0] wd);
      logic oe_e, ale_e, rd_e, wr_e;
      oe_e  = (ph <= 1) || wr;
      ale_e = (pin_dir[0] && ph == 0) ? ~idle_lvl[0] : idle_lvl[0];
      rd_e  = (pin_dir[1] && ph == 3 && !wr) ? ~idle_lvl[1] : idle_lvl[1];
      wr_e  = (pin_dir[2] && ph == 3 && wr) ? ~idle_lvl[2] : idle_lvl[2];
      cmp(tag, "busy", int'(host_busy), int'(ph != 0));
      cmp(tag, "ad_oe", int'(ad_oe), int'(oe_e));
      if (oe_e) cmp(tag, "ad_o", int'(ad_o), (ph <= 1) ? int'(m_addr) : int'(wd));
      cmp(tag, "ale", int'(ale_o), int'(ale_e));
      cmp(tag, "rd", int'(rd_o), int'(rd_e));
      cmp(tag, "wr", int'(wr_o), int'(wr_e));
      cmp("R8", "strobe_oe", int'(strobe_oe), int'(pin_dir));
      if (ph == 0) cmp(tag, "rdata", int'(host_rdata), int'(m_rdata));
   endtask

   task automatic set_addr(input logic [7:0] a);
      @(negedge clk);
      host_req = 1'b1; host_sel = 2'd0; host_we = 1'b1; host_wdata = a;
      @(negedge clk);
      host_req = 1'b0;
      m_addr = a;
      expect_state("R2", 0, 1'b0, 8'h00);
   endtask

   task automatic run_cycle(input logic [1:0] sel, input logic we, input logic [7:0] wd,
                            input logic [7:0] rv, input string tag);
      @(negedge clk);
      host_req = 1'b1; host_sel = sel; host_we = we; host_wdata = wd; ad_i = rv;
      @(negedge clk);
      host_req = 1'b0;
      for (int t = 0; t < TOT; t++) begin
         expect_state((t >= CA + CT + CS) ? "R10" : tag, phase_at(t), we, wd);
         if (t == 3) begin
            // R9: a request during a cycle is ignored
            host_req = 1'b1; host_sel = 2'd0; host_we = 1'b1; host_wdata = 8'hEE;
         end
         @(negedge clk);
         host_req = 1'b0;
      end
      if (!we) m_rdata = rv;
      if (sel == 2'd2) m_addr = m_addr + 8'h01;
      expect_state((sel == 2'd2) ? "R6" : "R9", 0, 1'b0, 8'h00);
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_state("R1", 0, 1'b0, 8'h00);

      set_addr(8'h5A);
      // R2: read of address alias and unused alias 3 do nothing
      @(negedge clk);
      host_req = 1'b1; host_sel = 2'd0; host_we = 1'b0;
      @(negedge clk);
      host_req = 1'b0;
      expect_state("R2", 0, 1'b0, 8'h00);
      host_req = 1'b1; host_sel = 2'd3; host_we = 1'b1; host_wdata = 8'h11;
      @(negedge clk);
      host_req = 1'b0;
      expect_state("R2", 0, 1'b0, 8'h00);

      run_cycle(2'd1, 1'b1, 8'hC3, 8'h00, "R5");
      run_cycle(2'd1, 1'b0, 8'h00, 8'h96, "R4");
      run_cycle(2'd1, 1'b1, 8'h3C, 8'h00, "R3");

      idle_lvl = 3'b000;   // R7: all active-high on idle 0
      run_cycle(2'd2, 1'b0, 8'h00, 8'h71, "R7");
      idle_lvl = 3'b010;
      run_cycle(2'd2, 1'b1, 8'hA5, 8'h00, "R7");

      set_addr(8'hFF);
      run_cycle(2'd2, 1'b1, 8'h0F, 8'h00, "R6");

      idle_lvl = 3'b111;
      pin_dir  = 3'b101;   // R8: read pin as input
      run_cycle(2'd1, 1'b0, 8'h00, 8'h2B, "R8");
      pin_dir  = 3'b010;   // R8: latch and write pins as inputs
      run_cycle(2'd2, 1'b1, 8'h44, 8'h00, "R8");
      pin_dir  = 3'b111;
      run_cycle(2'd1, 1'b0, 8'h00, 8'hD2, "R4");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule